// File: doc/BRIEF.md
# Protection Region Configuration Register File

This block holds the programming state of a small memory protection unit with a parameterised number of regions, from zero up to sixteen. Software reaches it through a word-wide register bus inside the system control space. There is one offset each for an identification word, a control word and a region selector. Every region has a base word and an attribute/size word, but only the region named by the selector can be reached at a time. The base and attribute/size words also answer at three extra address pairs. A write to one of them does the same as a write to the primary address.

The contents of every region, and the three control bits, come out of the block as parallel fields for the protection checker downstream. A single-cycle `cfgChanged` pulse follows every accepted write that changes protection state, so cached translations can be flushed. A single-cycle `cfgError` pulse marks writes that software should not issue. These are out-of-range region numbers and the unpredictable control combination. Reads return registered data one cycle after `rdEn`. Read data reflects the register state before any write made in the same cycle.

Top module: `mpu_cfg_regs`

## Requirements
- R1: The identification word at offset 0xD90 reads as the implemented region count shifted left by 8 (zero with no regions), and writes to it change nothing and give neither pulse.
- R2: The control word at 0xD94 keeps only written bits 0 (`ctrlEnable`), 1 (`ctrlFaultEnable`) and 2 (`ctrlPrivDefault`). It reads back as those three bits with all others zero, and every control write pulses `cfgChanged`.
- R3: A control write with bit 1 set and bit 0 clear is stored like any other control write and also pulses `cfgError`.
- R4: The selector at 0xD98 takes a written value only when the whole 32-bit value is below the region count. Otherwise the selector is unchanged and `cfgError` pulses. Selector writes never pulse `cfgChanged`.
- R5: The base word is decoded at 0xD9C, 0xDA4, 0xDAC and 0xDB4, and the attribute/size word at 0xDA0, 0xDA8, 0xDB0 and 0xDB8, with identical behaviour at every alias.
- R6: A base write with bit 4 set targets the region in bits [3:0] and also loads that number into the selector. If that region is not implemented, the whole write is dropped, the selector is kept and `cfgError` pulses.
- R7: A base write with bit 4 clear targets the region held in the selector and stores the written value with bits [4:0] cleared.
- R8: An attribute/size write stores written bits [15:0] AND 0xFF3F as the size field and written bits [31:16] AND 0x173F as the attribute field of the selected region.
- R9: A base read returns the stored base in bits [31:5], zero in bit 4 and the selector in bits [3:0]. An attribute/size read returns attributes in [31:16] and size in [15:0].
- R10: When the selected region is not implemented, base and attribute/size reads return zero and writes through the selector change nothing and give no pulse.
- R11: `cfgChanged` is high for exactly the one cycle after each accepted control, base or attribute/size write, and stays low after dropped, selector, identification or undecoded writes.
- R12: After reset every register, every output field and both pulses are zero, and reads of undecoded offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe; `rdData` valid the next cycle |
| addr | input | ADDR_W | Byte offset inside the system control window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| ctrlEnable | output | 1 | Protection enable bit |
| ctrlFaultEnable | output | 1 | Protection active in fault/NMI handlers |
| ctrlPrivDefault | output | 1 | Privileged default map enable |
| regionBase | output | SLOTS*32 | Base of region i in bits [i*32 +: 32] |
| regionSize | output | SLOTS*16 | Size/enable/subregion field of region i |
| regionAttr | output | SLOTS*16 | Attribute field of region i |
| cfgChanged | output | 1 | One-cycle pulse after a protection change |
| cfgError | output | 1 | One-cycle pulse after a bad write |

## Verification
The hardest case is a selected region that is not implemented. The selector only ever accepts in-range numbers, so with a non-zero region count this state cannot be reached from the ports at all. The bench therefore runs a second copy with zero regions on the same bus, compares both read ports against a model on every read, and so exercises the dropped-write and zero-read paths at each step. Out-of-range base writes with bit 4 set are mixed in after the selector has been moved, to show that the selector survives them.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;

  localparam int DATA_W = 32;

  localparam logic [11:0] OFS_IDENT = 12'hD90;
  localparam logic [11:0] OFS_CTRL  = 12'hD94;
  localparam logic [11:0] OFS_SEL   = 12'hD98;

  localparam logic [15:0] SIZE_MASK = 16'hFF3F;
  localparam logic [15:0] ATTR_MASK = 16'h173F;

  typedef enum logic [2:0] {
    RD_NONE, RD_IDENT, RD_CTRL, RD_SEL, RD_BASE, RD_ATTR
  } rdKind_e;

  typedef struct packed {
    logic    ctrlWe;
    logic    selWe;
    logic    baseWe;
    logic    attrWe;
    logic [3:0] tgtRegion;
    logic    badWrite;
    logic    rdEn;
    rdKind_e rdKind;
  } cfgStrobe_t;

  function automatic rdKind_e decodeOffset(input logic [11:0] a);
    case (a)
      OFS_IDENT: return RD_IDENT;
      OFS_CTRL:  return RD_CTRL;
      OFS_SEL:   return RD_SEL;
      12'hD9C, 12'hDA4, 12'hDAC, 12'hDB4: return RD_BASE;
      12'hDA0, 12'hDA8, 12'hDB0, 12'hDB8: return RD_ATTR;
      default:   return RD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mpu_cfg_ctrl.sv
module mpu_cfg_ctrl
  import mpu_cfg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        curSel,
  output cfgStrobe_t        strb
);

  localparam logic [31:0] NUM32 = 32'(NUM_REGIONS);

  rdKind_e kind;
  logic    curSelOk;
  logic    validTgtOk;

  assign kind       = decodeOffset(addr[11:0]);
  assign curSelOk   = {28'b0, curSel} < NUM32;
  assign validTgtOk = {28'b0, wrData[3:0]} < NUM32;

  always_comb begin
    strb           = '0;
    strb.rdEn      = rdEn;
    strb.rdKind    = kind;
    strb.tgtRegion = curSel;
    if (wrEn) begin
      unique case (kind)
        RD_CTRL: begin
          strb.ctrlWe   = 1'b1;
          strb.badWrite = wrData[1] & ~wrData[0];
        end
        RD_SEL: begin
          if (wrData < NUM32) begin
            strb.selWe     = 1'b1;
            strb.tgtRegion = wrData[3:0];
          end else begin
            strb.badWrite = 1'b1;
          end
        end
        RD_BASE: begin
          if (wrData[4]) begin
            if (validTgtOk) begin
              strb.baseWe    = 1'b1;
              strb.selWe     = 1'b1;
              strb.tgtRegion = wrData[3:0];
            end else begin
              strb.badWrite = 1'b1;
            end
          end else if (curSelOk) begin
            strb.baseWe = 1'b1;
          end
        end
        RD_ATTR: strb.attrWe = curSelOk;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mpu_cfg_dp.sv
module mpu_cfg_dp
  import mpu_cfg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int SLOTS       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strb,
  input  logic [31:0]        wrData,
  output logic [3:0]         curSel,
  output logic [2:0]         ctrlBits,
  output logic [31:0]        rdData,
  output logic [SLOTS*32-1:0] baseFlat,
  output logic [SLOTS*16-1:0] sizeFlat,
  output logic [SLOTS*16-1:0] attrFlat,
  output logic               cfgChanged,
  output logic               cfgError
);

  localparam logic [31:0] NUM32 = 32'(NUM_REGIONS);
  localparam int          MAX_R = 16;

  logic [2:0]  ctrlReg;
  logic [3:0]  selReg;
  logic [26:0] baseMem [MAX_R];
  logic [15:0] sizeMem [MAX_R];
  logic [15:0] attrMem [MAX_R];
  logic        selOk;
  logic [31:0] rdNext;

  assign selOk = {28'b0, selReg} < NUM32;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      selReg     <= '0;
      cfgChanged <= 1'b0;
      cfgError   <= 1'b0;
    end else begin
      if (strb.ctrlWe) ctrlReg <= wrData[2:0];
      if (strb.selWe)  selReg  <= strb.tgtRegion;
      cfgChanged <= strb.ctrlWe | strb.baseWe | strb.attrWe;
      cfgError   <= strb.badWrite;
    end
  end

  for (genvar i = 0; i < MAX_R; i++) begin : g_slot
    if (i < NUM_REGIONS) begin : g_impl
      logic hit;
      assign hit = strb.tgtRegion == 4'(i);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseMem[i] <= '0;
          sizeMem[i] <= '0;
          attrMem[i] <= '0;
        end else begin
          if (strb.baseWe && hit) baseMem[i] <= wrData[31:5];
          if (strb.attrWe && hit) begin
            sizeMem[i] <= wrData[15:0] & SIZE_MASK;
            attrMem[i] <= wrData[31:16] & ATTR_MASK;
          end
        end
      end
    end else begin : g_none
      assign baseMem[i] = '0;
      assign sizeMem[i] = '0;
      assign attrMem[i] = '0;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_out
    assign baseFlat[i*32 +: 32] = {baseMem[i], 5'b0};
    assign sizeFlat[i*16 +: 16] = sizeMem[i];
    assign attrFlat[i*16 +: 16] = attrMem[i];
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_IDENT: rdNext = NUM32 << 8;
      RD_CTRL:  rdNext = {29'b0, ctrlReg};
      RD_SEL:   rdNext = {28'b0, selReg};
      RD_BASE:  rdNext = selOk ? {baseMem[selReg], 1'b0, selReg} : '0;
      RD_ATTR:  rdNext = selOk ? {attrMem[selReg], sizeMem[selReg]} : '0;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  assign curSel   = selReg;
  assign ctrlBits = ctrlReg;

  assert_ctrl_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ctrlWe) |-> ctrlReg == $past(wrData[2:0]));

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_REGIONS == 0) || ({28'b0, selReg} < NUM32));

endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_cfg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 8,
  localparam int SLOTS      = (NUM_REGIONS == 0) ? 1 : NUM_REGIONS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  output logic                ctrlEnable,
  output logic                ctrlFaultEnable,
  output logic                ctrlPrivDefault,
  output logic [SLOTS*32-1:0] regionBase,
  output logic [SLOTS*16-1:0] regionSize,
  output logic [SLOTS*16-1:0] regionAttr,
  output logic                cfgChanged,
  output logic                cfgError
);

  cfgStrobe_t strb;
  logic [3:0] curSel;
  logic [2:0] ctrlBits;

  mpu_cfg_ctrl #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .curSel(curSel), .strb(strb)
  );

  mpu_cfg_dp #(.NUM_REGIONS(NUM_REGIONS), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curSel(curSel), .ctrlBits(ctrlBits), .rdData(rdData),
    .baseFlat(regionBase), .sizeFlat(regionSize), .attrFlat(regionAttr),
    .cfgChanged(cfgChanged), .cfgError(cfgError)
  );

  assign ctrlEnable      = ctrlBits[0];
  assign ctrlFaultEnable = ctrlBits[1];
  assign ctrlPrivDefault = ctrlBits[2];

  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    cfgChanged |-> $past(wrEn));

  assert_error_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> $past(wrEn));

  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> ($stable(regionBase) && $stable(regionAttr) && $stable(regionSize)));

endmodule

// File: tb/test_mpu_cfg_regs.sv
`timescale 1ns/1ps
module test_mpu_cfg_regs;

  localparam int NR = 8;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0, rdEn = 0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataE;
  logic        enA, fltA, privA, chgA, errA;
  logic        enE, fltE, privE, chgE, errE;
  logic [NR*32-1:0] baseA;
  logic [NR*16-1:0] sizeA, attrA;
  logic [31:0] baseE;
  logic [15:0] sizeE, attrE;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mpu_cfg_regs #(.NUM_REGIONS(NR)) i_mpu_cfg_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ctrlEnable(enA), .ctrlFaultEnable(fltA), .ctrlPrivDefault(privA),
    .regionBase(baseA), .regionSize(sizeA), .regionAttr(attrA),
    .cfgChanged(chgA), .cfgError(errA));

  mpu_cfg_regs #(.NUM_REGIONS(0)) i_mpu_cfg_regs_empty (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdDataE), .ctrlEnable(enE), .ctrlFaultEnable(fltE), .ctrlPrivDefault(privE),
    .regionBase(baseE), .regionSize(sizeE), .regionAttr(attrE),
    .cfgChanged(chgE), .cfgError(errE));

  // model state: index 0 = NR regions, index 1 = no regions
  logic [2:0]  mCtrl [2];
  logic [3:0]  mSel  [2];
  logic [31:0] mBase [16];
  logic [15:0] mSize [16];
  logic [15:0] mAttr [16];

  typedef struct { logic [31:0] e0; logic [31:0] e1; string tag; } rdItem_t;
  rdItem_t rdQ[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit isBase(input logic [11:0] a);
    return a inside {12'hD9C, 12'hDA4, 12'hDAC, 12'hDB4};
  endfunction
  function automatic bit isAttr(input logic [11:0] a);
    return a inside {12'hDA0, 12'hDA8, 12'hDB0, 12'hDB8};
  endfunction

  function automatic logic [31:0] expRead(input int k, input logic [11:0] a);
    int nr = (k == 0) ? NR : 0;
    bit ok = int'(mSel[k]) < nr;
    if (a == 12'hD90) return 32'(nr) << 8;
    if (a == 12'hD94) return {29'b0, mCtrl[k]};
    if (a == 12'hD98) return {28'b0, mSel[k]};
    if (isBase(a)) return ok ? (mBase[mSel[k]] | {28'b0, mSel[k]}) : 32'h0;
    if (isAttr(a)) return ok ? {mAttr[mSel[k]], mSize[mSel[k]]} : 32'h0;
    return 32'h0;
  endfunction

  // driver: read, pushes expected item for the monitor
  task automatic doRead(input logic [11:0] a, input string tag);
    rdItem_t it;
    it.e0 = expRead(0, a); it.e1 = expRead(1, a); it.tag = tag;
    rdQ.push_back(it);
    addr = a; rdEn = 1;
    @(posedge clk); @(negedge clk);
    rdEn = 0;
  endtask

  // monitor: pops expected reads as responses appear
  initial forever begin
    @(posedge clk);
    if (rdEn) begin
      rdItem_t it;
      @(negedge clk);
      it = rdQ.pop_front();
      check({it.tag, " main"}, rdData, it.e0);
      check({it.tag, " empty"}, rdDataE, it.e1);
    end
  end

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, input string tag);
    bit chg [2];
    bit err [2];
    for (int k = 0; k < 2; k++) begin
      int nr = (k == 0) ? NR : 0;
      chg[k] = 0; err[k] = 0;
      if (a == 12'hD94) begin
        mCtrl[k] = d[2:0]; chg[k] = 1; err[k] = d[1] & ~d[0];
      end else if (a == 12'hD98) begin
        if (d < 32'(nr)) mSel[k] = d[3:0]; else err[k] = 1;
      end else if (isBase(a)) begin
        if (d[4]) begin
          if (int'(d[3:0]) < nr) begin
            mSel[k] = d[3:0]; mBase[d[3:0]] = d & ~32'h1F; chg[k] = 1;
          end else err[k] = 1;
        end else if (int'(mSel[k]) < nr) begin
          mBase[mSel[k]] = d & ~32'h1F; chg[k] = 1;
        end
      end else if (isAttr(a)) begin
        if (int'(mSel[k]) < nr) begin
          mSize[mSel[k]] = d[15:0] & 16'hFF3F;
          mAttr[mSel[k]] = d[31:16] & 16'h173F; chg[k] = 1;
        end
      end
    end
    addr = a; wrData = d; wrEn = 1;
    @(posedge clk); @(negedge clk);
    wrEn = 0;
    check({"R11 change main ", tag}, 32'(chgA), 32'(chg[0]));
    check({"R11 change empty ", tag}, 32'(chgE), 32'(chg[1]));
    check({tag, " error main"}, 32'(errA), 32'(err[0]));
    check({tag, " error empty"}, 32'(errE), 32'(err[1]));
  endtask

  task automatic checkFields(input string tag);
    check({tag, " R2 ctrl main"}, {29'b0, privA, fltA, enA}, {29'b0, mCtrl[0]});
    check({tag, " R2 ctrl empty"}, {29'b0, privE, fltE, enE}, {29'b0, mCtrl[1]});
    for (int r = 0; r < NR; r++) begin
      check({tag, " R7 base"}, baseA[r*32 +: 32], mBase[r]);
      check({tag, " R8 size"}, {16'b0, sizeA[r*16 +: 16]}, {16'b0, mSize[r]});
      check({tag, " R8 attr"}, {16'b0, attrA[r*16 +: 16]}, {16'b0, mAttr[r]});
    end
    check({tag, " R10 empty fields"}, baseE | {sizeE, attrE}, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin mCtrl[k] = '0; mSel[k] = '0; end
    for (int r = 0; r < 16; r++) begin mBase[r] = '0; mSize[r] = '0; mAttr[r] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R12 reset state and undecoded reads
    check("R12 reset change", 32'(chgA | chgE), 32'h0);
    check("R12 reset error", 32'(errA | errE), 32'h0);
    checkFields("R12 reset");
    doRead(12'hD94, "R12 ctrl");
    doRead(12'hD9C, "R12 base");
    doRead(12'hD8C, "R12 undecoded");
    doRead(12'h000, "R12 undecoded low");

    // R1 identification word
    doRead(12'hD90, "R1 ident");
    doWrite(12'hD90, 32'hFFFF_FFFF, "R1 ident write");
    doRead(12'hD90, "R1 ident after write");

    // R2 control keeps three bits
    doWrite(12'hD94, 32'hFFFF_FFF5, "R2");
    doRead(12'hD94, "R2 readback");
    checkFields("R2");
    // R3 unpredictable combination
    doWrite(12'hD94, 32'h0000_0002, "R3");
    doRead(12'hD94, "R3 readback");
    doWrite(12'hD94, 32'h0000_0003, "R3 legal");

    // R4 selector range
    doWrite(12'hD98, 32'h5, "R4 in range");
    doRead(12'hD98, "R4 sel");
    doWrite(12'hD98, 32'h8, "R4 at limit");
    doWrite(12'hD98, 32'h1000_0003, "R4 high bits");
    doRead(12'hD98, "R4 sel kept");

    // R7 base through selector
    doWrite(12'hD9C, 32'h8000_1A2F, "R7");
    doRead(12'hD9C, "R9 base read");
    // R6 valid-bit write
    doWrite(12'hD9C, 32'h4000_0013, "R6");
    doRead(12'hD98, "R6 sel updated");
    doWrite(12'hD9C, 32'h5000_001A, "R6 out of range");
    doRead(12'hD98, "R6 sel kept");
    doRead(12'hD9C, "R6 base kept");

    // R8 attribute/size masks
    doWrite(12'hDA0, 32'hFFFF_FFFF, "R8 all ones");
    doRead(12'hDA0, "R9 attr read");
    doWrite(12'hDA0, 32'h0A5C_12C5, "R8 pattern");
    doRead(12'hDA0, "R9 attr pattern");

    // R5 aliases
    doWrite(12'hDA4, 32'h1111_1131, "R5 base alias1");
    doWrite(12'hDA8, 32'h1234_5678, "R5 attr alias1");
    doWrite(12'hDAC, 32'h2222_2252, "R5 base alias2");
    doWrite(12'hDB0, 32'hFEDC_BA98, "R5 attr alias2");
    doWrite(12'hDB4, 32'h7777_77F7, "R5 base alias3");
    doWrite(12'hDB8, 32'h0F0F_F0F0, "R5 attr alias3");
    doRead(12'hDB8, "R5 attr alias3 read");
    doRead(12'hDB4, "R5 base alias3 read");
    doWrite(12'hD98, 32'h1, "R5 select 1");
    doRead(12'hDA4, "R5 base alias1 read");
    doRead(12'hDA8, "R5 attr alias1 read");
    doWrite(12'hDAC, 32'h0000_0F00, "R7 via alias");
    doRead(12'hD9C, "R9 base after alias");

    // R10 unimplemented selection (empty copy) and R11 quiet writes
    doWrite(12'hD9C, 32'h6000_0010, "R10 valid write region 0");
    doWrite(12'hDA0, 32'h0000_0001, "R10 attr write");
    doWrite(12'hD8C, 32'hFFFF_FFFF, "R11 undecoded write");
    doRead(12'hDA0, "R10 attr read");
    doRead(12'hD9C, "R10 base read");
    checkFields("R10 end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule